// File: doc/BRIEF.md
# Sklansky Parallel-Prefix Adder

This block adds two unsigned operands of `W` bits (16 by default) and returns a `W`-bit sum together with a carry-out. The carry network is built by hand as a parallel-prefix tree with divide-and-conquer wiring. It uses log2(W) levels, which is four for 16 bits. At each level, every node in the upper half of a block takes the group term of the top node of the lower half. As a result, a few nodes drive many cells.

The datapath has three stages. The first forms a generate term and a propagate term for each bit. The second is the prefix tree, made of three kinds of cell:

- a full cell, which produces both the group generate and the group propagate;
- a reduced cell, which produces the group generate only and is used where the new span reaches bit 0;
- a buffer stage, which passes a node on unchanged, so that every level is present as a visible net.

The third stage combines each propagate bit with the carry from the bits below it. The sum and the carry-out are captured in registers that have a synchronous active-high reset. A result therefore appears one clock after its operands. There is no carry input.

Top module: `sklansky_adder`

## Requirements
- R1: One clock edge after operands `op_a` and `op_b` are sampled with `rst` low, `{cout_q, sum_q}` equals the unsigned (W+1)-bit sum of those operands.
- R2: When `rst` is high at a rising clock edge, `sum_q` and `cout_q` become 0 after that edge, whatever the operand values.
- R3: When every bit position has exactly one operand bit set (`op_a ^ op_b` all ones), the result is all ones and `cout_q` is 0.
- R4: `cout_q` is 1 exactly when the true sum is 2^W or more. For example, 0xFFFF+0x0002 gives 0x0001 with carry 1, and 0xFFFF+0xFFEE gives 0xFFED with carry 1.
- R5: Sum bit 0 equals `op_a[0] ^ op_b[0]`, because the carry-in is fixed at zero.
- R6: The longest carry path, from bit 0 into bit W-1, gives the correct result. 0x7FFF+0x0001 must give 0x8000 with carry 0.
- R7: Operands with mixed generate, propagate and kill patterns give the correct sum. 0x11FF+0xEDAB gives 0xFFAA with carry 0, 0xCC53+0xD126 gives 0x9D79 with carry 1, 0x4444+0x7777 gives 0xBBBB with carry 0, and 0xFFFF+0xFFFF gives 0xFFFE with carry 1.
- R8: Adding a zero `op_b` returns `op_a` unchanged, with `cout_q` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result registers |
| rst | input | 1 | Synchronous active-high reset of the result |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sum_q | output | W | Registered sum |
| cout_q | output | 1 | Registered carry-out |

## Verification
The bound checker compares the registered result against the sum of the previous cycle's operands on every clock edge. On every edge it also checks the reset clearing, the all-propagate pattern, the sum bit 0 and the zero-operand identity.

Whether the prefix wiring really carries a generate from bit 0 across all four levels can only be shown by the bench's operand choices. The same holds for the named corner pairs and for a broad random sweep. These scenarios target the longest chain and the nodes with high fan-out.

// File: rtl/skl_pkg.sv
package skl_pkg;

  // Generate/propagate pair of one bit or one span.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

endpackage

// File: rtl/skl_cells.sv
// Prefix cells: full combine, reduced combine (span reaching bit 0), buffer.
module skl_dot_full
  import skl_pkg::*;
(
  input  gp_t hi,
  input  gp_t lo,
  output gp_t y
);
  assign y.g = hi.g | (hi.p & lo.g);
  assign y.p = hi.p & lo.p;
endmodule

module skl_dot_gray
  import skl_pkg::*;
(
  input  gp_t  hi,
  input  logic lo_g,
  output gp_t  y
);
  // Span now ends at bit 0: only the group generate matters downstream.
  assign y.g = hi.g | (hi.p & lo_g);
  assign y.p = 1'b0;
endmodule

module skl_buf
  import skl_pkg::*;
(
  input  gp_t a,
  output gp_t y
);
  assign y = a;
endmodule

// File: rtl/skl_pre.sv
module skl_pre
  import skl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output gp_t          bit_gp [0:W-1]
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_gp[i].g = op_a[i] & op_b[i];
    assign bit_gp[i].p = op_a[i] ^ op_b[i];
  end
endmodule

// File: rtl/skl_tree.sv
// Divide-and-conquer prefix tree. At level lv a node whose index has bit lv
// set merges with the top node of the lower half of its 2^(lv+1) block.
module skl_tree
  import skl_pkg::*;
#(
  parameter int W = 16
) (
  input  gp_t          bit_gp [0:W-1],
  output logic [W-1:0] grp_g
);
  localparam int LVL = $clog2(W);

  gp_t  nd [0:LVL][0:W-1];
  logic [W-1:0] last_p;
  logic unused_last_p;

  for (genvar i = 0; i < W; i++) begin : g_in
    assign nd[0][i] = bit_gp[i];
  end

  for (genvar lv = 0; lv < LVL; lv++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_node
      if (((i >> lv) & 1) == 1) begin : g_merge
        localparam int LOW   = ((i >> lv) << lv) - 1;
        localparam int START = (i >> (lv + 1)) << (lv + 1);
        if (START == 0) begin : g_red
          skl_dot_gray u_cell (
            .hi   (nd[lv][i]),
            .lo_g (nd[lv][LOW].g),
            .y    (nd[lv+1][i])
          );
        end else begin : g_full
          skl_dot_full u_cell (
            .hi (nd[lv][i]),
            .lo (nd[lv][LOW]),
            .y  (nd[lv+1][i])
          );
        end
      end else begin : g_pass
        skl_buf u_buf (
          .a (nd[lv][i]),
          .y (nd[lv+1][i])
        );
      end
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_out
    assign grp_g[i]  = nd[LVL][i].g;
    assign last_p[i] = nd[LVL][i].p;
  end

  // Spans ending at bit 0 carry no useful propagate term.
  assign unused_last_p = ^last_p;
endmodule

// File: rtl/skl_post.sv
module skl_post #(
  parameter int W = 16
) (
  input  logic [W-1:0] p_bit,
  input  logic [W-1:0] grp_g,
  output logic [W-1:0] sum,
  output logic         cout
);
  assign sum[0] = p_bit[0];
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign sum[i] = p_bit[i] ^ grp_g[i-1];
  end
  assign cout = grp_g[W-1];
endmodule

// File: rtl/sklansky_adder.sv
module sklansky_adder
  import skl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum_q,
  output logic         cout_q
);
  gp_t          bit_gp [0:W-1];
  logic [W-1:0] p_bit;
  logic [W-1:0] grp_g;
  logic [W-1:0] sum_d;
  logic         cout_d;

  skl_pre #(.W(W)) u_pre (
    .op_a   (op_a),
    .op_b   (op_b),
    .bit_gp (bit_gp)
  );

  for (genvar i = 0; i < W; i++) begin : g_p
    assign p_bit[i] = bit_gp[i].p;
  end

  skl_tree #(.W(W)) u_tree (
    .bit_gp (bit_gp),
    .grp_g  (grp_g)
  );

  skl_post #(.W(W)) u_post (
    .p_bit (p_bit),
    .grp_g (grp_g),
    .sum   (sum_d),
    .cout  (cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end
endmodule

// File: rtl/skl_adder_chk.sv
module skl_adder_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] sum_q,
  input logic         cout_q
);
  assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout_q, sum_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cout_q));

  assert_all_prop_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_a ^ op_b) == '1)) |-> (sum_q == '1 && !cout_q));

  assert_bit0_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sum_q[0] == ($past(op_a[0]) ^ $past(op_b[0]))));

  assert_zero_b_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_b) == '0) |-> (sum_q == $past(op_a) && !cout_q));
endmodule

bind sklansky_adder skl_adder_chk #(.W(W)) u_chk (.*);

// File: tb/tb_sklansky_adder.sv
module tb_sklansky_adder;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] sum_q;
  logic         cout_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sklansky_adder #(.W(W)) dut (
    .clk    (clk),
    .rst    (rst),
    .op_a   (op_a),
    .op_b   (op_b),
    .sum_q  (sum_q),
    .cout_q (cout_q)
  );

  task automatic check(input logic [W:0] got, input logic [W:0] exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Apply one pair, then sample one edge later, 1 ns after the edge.
  task automatic run_pair(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    logic [W:0] exp;
    @(negedge clk);
    op_a = x;
    op_b = y;
    @(posedge clk);
    #1;
    exp = {1'b0, x} + {1'b0, y};
    check({cout_q, sum_q}, exp, req);
  endtask

  task automatic t_reset();
    @(posedge clk);
    #1;
    check({cout_q, sum_q}, '0, "R2 initial reset");
    @(negedge clk);
    op_a = 16'hFFFF;
    op_b = 16'hFFFF;
    @(posedge clk);
    #1;
    check({cout_q, sum_q}, '0, "R2 reset holds with live operands");
    @(negedge clk);
    rst = 1'b0;
    run_pair(16'h1234, 16'h9782, "R1 first pair after reset");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check({cout_q, sum_q}, '0, "R2 mid-run reset clears");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_worst();
    run_pair(16'h7FFF, 16'h0001, "R6 longest carry 7FFF+0001");
    check({cout_q, sum_q}, 17'h08000, "R6 literal 8000");
    run_pair(16'h0001, 16'h7FFF, "R6 swapped operands");
  endtask

  task automatic t_carry_out();
    run_pair(16'hFFFF, 16'h0002, "R4 FFFF+0002");
    check({cout_q, sum_q}, 17'h10001, "R4 literal 1_0001");
    run_pair(16'hFFFF, 16'hFFEE, "R4 FFFF+FFEE");
    check({cout_q, sum_q}, 17'h1FFED, "R4 literal 1_FFED");
    run_pair(16'h8000, 16'h8000, "R4 top bits only");
  endtask

  task automatic t_mixed();
    run_pair(16'h11FF, 16'hEDAB, "R7 11FF+EDAB");
    check({cout_q, sum_q}, 17'h0FFAA, "R7 literal FFAA");
    run_pair(16'hCC53, 16'hD126, "R7 CC53+D126");
    check({cout_q, sum_q}, 17'h19D79, "R7 literal 1_9D79");
    run_pair(16'h4444, 16'h7777, "R7 4444+7777");
    check({cout_q, sum_q}, 17'h0BBBB, "R7 literal BBBB");
    run_pair(16'hFFFF, 16'hFFFF, "R7 FFFF+FFFF");
    check({cout_q, sum_q}, 17'h1FFFE, "R7 literal 1_FFFE");
  endtask

  task automatic t_all_prop();
    run_pair(16'hAAAA, 16'h5555, "R3 alternating propagate");
    check({cout_q, sum_q}, 17'h0FFFF, "R3 literal FFFF");
    run_pair(16'hF0F0, 16'h0F0F, "R3 nibble propagate");
  endtask

  task automatic t_bit0();
    run_pair(16'h0001, 16'h0001, "R5 bit0 both set");
    check({16'h0, sum_q[0]}, 17'h0, "R5 bit0 cleared");
    run_pair(16'h0001, 16'h0000, "R5 bit0 one set");
    check({16'h0, sum_q[0]}, 17'h1, "R5 bit0 set");
  endtask

  task automatic t_zero();
    run_pair(16'hBEEF, 16'h0000, "R8 zero operand");
    check({cout_q, sum_q}, {1'b0, 16'hBEEF}, "R8 identity");
    run_pair(16'h0000, 16'h0000, "R8 both zero");
  endtask

  task automatic t_random();
    for (int k = 0; k < 600; k++) begin
      run_pair(W'($urandom), W'($urandom), "R1 random pair");
    end
    for (int s = 0; s < W; s++) begin
      run_pair(W'(1) << s, ~(W'(0)) >> (W - 1 - s) << 0, "R4 carry from bit span");
    end
  endtask

  initial begin
    t_reset();
    t_worst();
    t_carry_out();
    t_mixed();
    t_all_prop();
    t_bit0();
    t_zero();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule